// File: doc/BRIEF.md
# Multi-Byte Serial Character Transmitter

This block sends a 40-bit word on an asynchronous serial line as five consecutive characters, each one carrying 8 data bits. When a single-cycle start pulse arrives and the block is idle, the block builds the complete line image for the whole word. Each byte gets a low start bit in front of it and a high stop bit behind it, which gives 50 bits in total. The block loads this image into one shift register in a single cycle. A baud divider then moves the image out one bit per bit period. No per-byte sequencer is involved.

The bit rate comes from a 3-bit select input. The block samples it together with the word when a transfer starts. The divisor is the clock frequency divided by the chosen rate; at 50 MHz this equals 1e9 / rate / 20 cycles. When the last stop bit has been on the line for a full period, a completion flag goes high. It stays high until the next accepted start. The line rests high whenever no transfer is running.

Top module: `multibyte_serial_tx`

## Requirements
- R1: While reset is low, and after it is released with no start, `tx_o` is 1 and `done_o` is 0.
- R2: The line carries bit positions 0 to 49 in order. Slot b (b = 0..4) occupies positions 10b to 10b+9. Position 10b is 0 (start bit). Position 10b+1+j is `word_i[8b+j]` for j = 0..7, so bytes go out lowest byte first and bits go out lowest bit first. Position 10b+9 is 1 (stop bit).
- R3: Every bit lasts exactly CLK_HZ / rate clock cycles. Select codes 0, 1, 2, 3 and 4 give 9600, 19200, 38400, 57600 and 115200 baud.
- R4: Select codes 5, 6 and 7 use the 115200 baud divisor.
- R5: A start pulse seen while idle is accepted at that clock edge. From the next cycle the line shows the first start bit (0) and `done_o` is 0.
- R6: `done_o` rises exactly 50 bit periods after the accepting edge, with `tx_o` high. Both hold until the next accepted start.
- R7: A start pulse that arrives while a transfer is running has no effect. The waveform is unchanged, and no extra transfer follows.
- R8: Changes to `word_i` or `baud_sel_i` after the accepting edge do not change the transfer in progress.
- R9: A start pulse given in the first cycle in which `done_o` is high is accepted at once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Single-cycle transfer request |
| word_i | input | 40 | Word to send (NUM_BYTES*8 bits) |
| baud_sel_i | input | 3 | Bit-rate code |
| tx_o | output | 1 | Serial line, idles high |
| done_o | output | 1 | Transfer complete flag |

## Verification
The line is compared with an expected 50-bit image in every cycle of each transfer. This catches byte-order, bit-order and framing errors, and it also catches bit periods that are off by a single cycle. Words of all zeros, all ones and alternating patterns separate start bits and stop bits from data bits. Two ascending-byte words catch swapped slots. Every select code is used, including the three unassigned codes, so that a wrong divisor entry shows up as skew. Some transfers inject a start pulse and change the word and the select input halfway through, then watch the idle line afterwards, so that a retrigger or a late capture can be seen. Random words and codes from a fixed seed fill in the remaining space.

// File: rtl/mbtx_pkg.sv
package mbtx_pkg;
  localparam int unsigned CHAR_BITS = 8;
  localparam int unsigned SLOT_BITS = CHAR_BITS + 2;

  // bit rate in Hz for each select code; unassigned codes use the fastest rate
  function automatic int unsigned rate_hz(input int unsigned code);
    case (code)
      0:       rate_hz = 9600;
      1:       rate_hz = 19200;
      2:       rate_hz = 38400;
      3:       rate_hz = 57600;
      default: rate_hz = 115200;
    endcase
  endfunction
endpackage

// File: rtl/mbtx_rst_sync.sv
module mbtx_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic srst_n
);
  logic meta_q;
  logic hold_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= 1'b0;
      hold_q <= 1'b0;
    end else begin
      meta_q <= 1'b1;
      hold_q <= meta_q;
    end
  end

  assign srst_n = hold_q;
endmodule

// File: rtl/mbtx_frame_pack.sv
module mbtx_frame_pack #(
  parameter int unsigned NUM_BYTES = 5
) (
  input  logic [NUM_BYTES*mbtx_pkg::CHAR_BITS-1:0] word_i,
  output logic [NUM_BYTES*mbtx_pkg::SLOT_BITS-1:0] frame_o
);
  localparam int unsigned CB = mbtx_pkg::CHAR_BITS;
  localparam int unsigned SB = mbtx_pkg::SLOT_BITS;

  for (genvar g = 0; g < NUM_BYTES; g++) begin : g_slot
    // slot layout, first bit out at the lowest index: start, data LSB..MSB, stop
    assign frame_o[g*SB +: SB] = {1'b1, word_i[g*CB +: CB], 1'b0};
  end
endmodule

// File: rtl/mbtx_baud_gen.sv
module mbtx_baud_gen #(
  parameter int unsigned CLK_HZ = 50_000_000,
  parameter int unsigned DIV_W  = 13
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_i,
  input  logic             run_i,
  input  logic [2:0]       sel_i,
  output logic             tick_o,
  output logic [DIV_W-1:0] cnt_o,
  output logic [DIV_W-1:0] div_o
);
  localparam logic [DIV_W-1:0] DIV0 = DIV_W'(CLK_HZ / mbtx_pkg::rate_hz(0));
  localparam logic [DIV_W-1:0] DIV1 = DIV_W'(CLK_HZ / mbtx_pkg::rate_hz(1));
  localparam logic [DIV_W-1:0] DIV2 = DIV_W'(CLK_HZ / mbtx_pkg::rate_hz(2));
  localparam logic [DIV_W-1:0] DIV3 = DIV_W'(CLK_HZ / mbtx_pkg::rate_hz(3));
  localparam logic [DIV_W-1:0] DIV4 = DIV_W'(CLK_HZ / mbtx_pkg::rate_hz(4));

  logic [DIV_W-1:0] div_sel;
  logic [DIV_W-1:0] div_q, div_d;
  logic [DIV_W-1:0] cnt_q, cnt_d;

  always_comb begin
    case (sel_i)
      3'd0:    div_sel = DIV0;
      3'd1:    div_sel = DIV1;
      3'd2:    div_sel = DIV2;
      3'd3:    div_sel = DIV3;
      default: div_sel = DIV4;
    endcase
  end

  assign tick_o = run_i && (cnt_q == (div_q - DIV_W'(1)));

  always_comb begin
    div_d = div_q;
    cnt_d = cnt_q;
    if (load_i) begin
      div_d = div_sel;
      cnt_d = '0;
    end else if (run_i) begin
      cnt_d = tick_o ? '0 : cnt_q + DIV_W'(1);
    end else begin
      cnt_d = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_q <= '0;
      cnt_q <= '0;
    end else begin
      div_q <= div_d;
      cnt_q <= cnt_d;
    end
  end

  assign cnt_o = cnt_q;
  assign div_o = div_q;
endmodule

// File: rtl/mbtx_shifter.sv
module mbtx_shifter #(
  parameter int unsigned FRAME_BITS = 50,
  parameter int unsigned IDX_W      = 6
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  load_i,
  input  logic [FRAME_BITS-1:0] frame_i,
  input  logic                  tick_i,
  output logic                  line_o,
  output logic                  busy_o,
  output logic                  done_o,
  output logic [IDX_W-1:0]      idx_o
);
  logic [FRAME_BITS-1:0] sh_q, sh_d;
  logic                  busy_q, busy_d;
  logic                  done_q, done_d;
  logic [IDX_W-1:0]      idx_q, idx_d;

  always_comb begin
    sh_d   = sh_q;
    busy_d = busy_q;
    done_d = done_q;
    idx_d  = idx_q;
    if (load_i) begin
      sh_d   = frame_i;
      busy_d = 1'b1;
      done_d = 1'b0;
      idx_d  = '0;
    end else if (tick_i) begin
      sh_d = {1'b1, sh_q[FRAME_BITS-1:1]};
      if (idx_q == IDX_W'(FRAME_BITS - 1)) begin
        busy_d = 1'b0;
        done_d = 1'b1;
        idx_d  = '0;
      end else begin
        idx_d = idx_q + IDX_W'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q   <= '1;
      busy_q <= 1'b0;
      done_q <= 1'b0;
      idx_q  <= '0;
    end else begin
      sh_q   <= sh_d;
      busy_q <= busy_d;
      done_q <= done_d;
      idx_q  <= idx_d;
    end
  end

  assign line_o = sh_q[0];
  assign busy_o = busy_q;
  assign done_o = done_q;
  assign idx_o  = idx_q;
endmodule

// File: rtl/multibyte_serial_tx.sv
module multibyte_serial_tx #(
  parameter int unsigned CLK_HZ    = 50_000_000,
  parameter int unsigned NUM_BYTES = 5
) (
  input  logic                                     clk,
  input  logic                                     rst_n,
  input  logic                                     start_i,
  input  logic [NUM_BYTES*mbtx_pkg::CHAR_BITS-1:0] word_i,
  input  logic [2:0]                               baud_sel_i,
  output logic                                     tx_o,
  output logic                                     done_o
);
  localparam int unsigned FRAME_BITS = NUM_BYTES * mbtx_pkg::SLOT_BITS;
  localparam int unsigned MAX_DIV    = CLK_HZ / mbtx_pkg::rate_hz(0);
  localparam int unsigned DIV_W      = $clog2(MAX_DIV + 1);
  localparam int unsigned IDX_W      = $clog2(FRAME_BITS);

  logic                  srst_n;
  logic                  busy;
  logic                  tick;
  logic                  accept;
  logic [FRAME_BITS-1:0] frame;
  logic [DIV_W-1:0]      div_cnt;
  logic [DIV_W-1:0]      div_val;
  logic [IDX_W-1:0]      bit_idx;

  assign accept = start_i && !busy;

  mbtx_rst_sync u_rst (
    .clk    (clk),
    .rst_n  (rst_n),
    .srst_n (srst_n)
  );

  mbtx_frame_pack #(.NUM_BYTES(NUM_BYTES)) u_pack (
    .word_i  (word_i),
    .frame_o (frame)
  );

  mbtx_baud_gen #(.CLK_HZ(CLK_HZ), .DIV_W(DIV_W)) u_baud (
    .clk    (clk),
    .rst_n  (srst_n),
    .load_i (accept),
    .run_i  (busy),
    .sel_i  (baud_sel_i),
    .tick_o (tick),
    .cnt_o  (div_cnt),
    .div_o  (div_val)
  );

  mbtx_shifter #(.FRAME_BITS(FRAME_BITS), .IDX_W(IDX_W)) u_shift (
    .clk     (clk),
    .rst_n   (srst_n),
    .load_i  (accept),
    .frame_i (frame),
    .tick_i  (tick),
    .line_o  (tx_o),
    .busy_o  (busy),
    .done_o  (done_o),
    .idx_o   (bit_idx)
  );
endmodule

// File: rtl/mbtx_checker.sv
module mbtx_checker #(
  parameter int unsigned FRAME_BITS = 50,
  parameter int unsigned DIV_W      = 13,
  parameter int unsigned IDX_W      = 6
) (
  input logic             clk,
  input logic             srst_n,
  input logic             start_i,
  input logic             tx_o,
  input logic             done_o,
  input logic             busy,
  input logic [DIV_W-1:0] div_cnt,
  input logic [DIV_W-1:0] div_val,
  input logic [IDX_W-1:0] bit_idx
);
  // R5
  accept_start_bit_chk: assert property (@(posedge clk) disable iff (!srst_n)
    (start_i && !busy) |=> (!tx_o && !done_o && busy));

  // R6
  done_idle_chk: assert property (@(posedge clk) disable iff (!srst_n)
    done_o |-> (tx_o && !busy));

  // R6
  finish_done_chk: assert property (@(posedge clk) disable iff (!srst_n)
    $fell(busy) |-> done_o);

  // R2
  last_stop_high_chk: assert property (@(posedge clk) disable iff (!srst_n)
    $rose(done_o) |-> $past(tx_o));

  // R2
  bit_idx_range_chk: assert property (@(posedge clk) disable iff (!srst_n)
    bit_idx <= IDX_W'(FRAME_BITS - 1));

  // R3
  div_range_chk: assert property (@(posedge clk) disable iff (!srst_n)
    busy |-> (div_cnt < div_val));

  // R8
  cfg_hold_chk: assert property (@(posedge clk) disable iff (!srst_n)
    busy |=> $stable(div_val));
endmodule

bind multibyte_serial_tx mbtx_checker #(
  .FRAME_BITS (FRAME_BITS),
  .DIV_W      (DIV_W),
  .IDX_W      (IDX_W)
) u_chk (
  .clk     (clk),
  .srst_n  (srst_n),
  .start_i (start_i),
  .tx_o    (tx_o),
  .done_o  (done_o),
  .busy    (busy),
  .div_cnt (div_cnt),
  .div_val (div_val),
  .bit_idx (bit_idx)
);

// File: tb/multibyte_serial_tx_tb_top.sv
module multibyte_serial_tx_tb_top;
  localparam int unsigned TB_CLK_HZ = 460_800;

  logic        clk;
  logic        rst_n;
  logic        start_i;
  logic [39:0] word_i;
  logic [2:0]  baud_sel_i;
  logic        tx_o;
  logic        done_o;

  int checks;
  int failures;

  multibyte_serial_tx #(.CLK_HZ(TB_CLK_HZ), .NUM_BYTES(5)) dut_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .start_i    (start_i),
    .word_i     (word_i),
    .baud_sel_i (baud_sel_i),
    .tx_o       (tx_o),
    .done_o     (done_o)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  function automatic logic [49:0] exp_frame(input logic [39:0] w);
    logic [49:0] f;
    for (int b = 0; b < 5; b++) begin
      f[10*b] = 1'b0;
      for (int j = 0; j < 8; j++) f[10*b+1+j] = w[8*b+j];
      f[10*b+9] = 1'b1;
    end
    return f;
  endfunction

  function automatic int exp_div(input logic [2:0] code);
    case (code)
      3'd0:    return TB_CLK_HZ / 9600;
      3'd1:    return TB_CLK_HZ / 19200;
      3'd2:    return TB_CLK_HZ / 38400;
      3'd3:    return TB_CLK_HZ / 57600;
      default: return TB_CLK_HZ / 115200;
    endcase
  endfunction

  task automatic chk(input bit ok, input string req, input logic [63:0] got, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s got=%0h exp=%0h at %0t", req, got, exp, $time);
    end
  endtask

  // one transfer; poke injects a start and new inputs midway (R7, R8)
  task automatic run_xfer(input logic [39:0] w, input logic [2:0] code, input bit poke);
    logic [49:0] f;
    int d;
    int total;
    f = exp_frame(w);
    d = exp_div(code);
    total = 50 * d;
    @(negedge clk);
    word_i = w;
    baud_sel_i = code;
    start_i = 1'b1;
    for (int k = 0; k <= total; k++) begin
      @(negedge clk);
      if (k == 0) begin
        start_i = 1'b0;
        // R5 / R9: done cleared, start bit on the line
        chk(done_o == 1'b0, "R5/R9 done cleared", {63'd0, done_o}, 64'd0);
      end
      if (k < total) begin
        // R2 / R3 / R4: expected bit for this cycle
        chk(tx_o == f[k/d], "R2/R3/R4 line bit", {63'd0, tx_o}, {63'd0, f[k/d]});
        if (k == total - 1)
          chk(done_o == 1'b0, "R6 done early", {63'd0, done_o}, 64'd0);
      end else begin
        chk(done_o == 1'b1, "R6 done at end", {63'd0, done_o}, 64'd1);
        chk(tx_o == 1'b1, "R6 idle line", {63'd0, tx_o}, 64'd1);
      end
      if (poke && k == 3*d + 1) begin
        start_i = 1'b1;
        word_i = ~w;
        baud_sel_i = code ^ 3'd1;
      end
      if (poke && k == 3*d + 2) start_i = 1'b0;
      if (k == 5*d) word_i = {$urandom, $urandom} ;
    end
    if (poke) begin
      for (int k = 0; k < 3*d; k++) begin
        @(negedge clk);
        // R7: no extra transfer after an ignored start
        chk(tx_o == 1'b1 && done_o == 1'b1, "R7 stays idle", {62'd0, tx_o, done_o}, 64'd3);
      end
    end
  endtask

  initial begin
    int unsigned seed0;
    checks = 0;
    failures = 0;
    rst_n = 1'b0;
    start_i = 1'b0;
    word_i = '0;
    baud_sel_i = 3'd4;
    seed0 = $urandom(32'd20240);
    repeat (3) @(negedge clk);
    // R1
    chk(tx_o == 1'b1 && done_o == 1'b0, "R1 in reset", {62'd0, tx_o, done_o}, 64'd2);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    chk(tx_o == 1'b1 && done_o == 1'b0, "R1 after reset", {62'd0, tx_o, done_o}, 64'd2);

    run_xfer(40'h123456789a, 3'd4, 1'b0);
    run_xfer(40'ha987654321, 3'd3, 1'b0);
    run_xfer(40'h0000000000, 3'd2, 1'b0);
    run_xfer(40'hffffffffff, 3'd1, 1'b0);
    run_xfer(40'h55aa55aa55, 3'd0, 1'b0);
    run_xfer(40'h0102030405, 3'd5, 1'b0);
    run_xfer(40'h8001800180, 3'd6, 1'b0);
    run_xfer(40'hc3c3c3c3c3, 3'd7, 1'b0);
    run_xfer(40'h5a5a0ff0a5, 3'd3, 1'b1);
    run_xfer(40'h00ff00ff00, 3'd0, 1'b1);
    for (int n = 0; n < 8; n++) begin
      logic [39:0] rw;
      logic [2:0]  rc;
      rw = {$urandom, $urandom};
      rc = 3'($urandom % 8);
      run_xfer(rw, rc, n[0]);
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired got=running exp=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule